// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects up to eight interrupt request lines for a microprogrammed sequencer. It catches each rising edge into a sticky pending bit. A loadable mask hides chosen lines. A priority encoder selects the highest unmasked pending line, and a higher line number means a higher priority. A fence register holds the lowest level that may currently interrupt. The encoded index passes only when it is greater than or equal to the fence. When it passes, the block pulls an active-low condition output low for the sequencer's conditional test, and it presents the index on a vector output marked by a valid flag.

Strobes from the sequencer's pipeline drive the block. One strobe stores the index now being serviced. Another drives a decoder that clears that one stored line. A clear bus with the same bit layout as the mask removes any subset of pending bits at once. The fence can be raised to the serviced index plus one, so only higher levels can then nest above the current handler. Both the fence and the mask are readable and loadable, so firmware can save them and later restore them to unwind a nest.

The vector output is a level presentation with no back-pressure. The consumer must sample `vec_idx` only in a cycle where `vec_valid` is high, and it cannot stall it. Every other pin is a plain control or status signal.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset all pending bits are zero, the mask reads 8'hFF (all lines enabled) and the fence reads 0, so `cond_n` is 1, `vec_valid` is 0 and `vec_idx` is 0.
- R2: A pending bit is set by a 0-to-1 transition on its `irq_in` line and stays set after the line falls. A line held high after its bit has been cleared does not set the bit again until it goes low and rises once more.
- R3: A pending line whose mask bit is 0 has no effect on `cond_n`, `vec_valid` or `vec_idx`. Writing a 1 to that mask bit exposes it again without a new edge.
- R4: The encoded index is the highest-numbered line that is both pending and unmasked; line 7 has the highest priority.
- R5: `vec_valid` is 1 and `cond_n` is 0 exactly when some unmasked line is pending and its encoded index is greater than or equal to the fence. In every other case `cond_n` is 1, `vec_valid` is 0 and `vec_idx` is 0.
- R6: `fence_inc` loads the fence with the current encoded index plus one, so fence values run from 0 to 8. `fence_wr` loads `fence_wdata` and takes priority when both are strobed in the same cycle.
- R7: `cap_stb` stores the current encoded index. `clr_stb` then clears only the pending bit of the stored line, one clock later.
- R8: While `clr_bus_stb` is 1, every pending bit whose `clr_bus` bit is 1 is cleared at the next edge, so one, several or all lines can be cleared at once.
- R9: If a line is cleared and a new rising edge arrives on that same line in the same cycle, the bit ends up set.
- R10: `mask_wr` loads `mask_wdata`, and `mask_rd` and `fence_rd` always show the stored mask and fence values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Raw request lines, edge-captured |
| mask_wr | input | 1 | Load mask register |
| mask_wdata | input | 8 | New mask value, 1 = line enabled |
| mask_rd | output | 8 | Current mask value |
| fence_wr | input | 1 | Load fence from `fence_wdata` |
| fence_inc | input | 1 | Load fence with encoded index + 1 |
| fence_wdata | input | 4 | New fence value |
| fence_rd | output | 4 | Current fence value |
| cap_stb | input | 1 | Store the current encoded index as the serviced line |
| clr_stb | input | 1 | Clear the pending bit of the stored line |
| clr_bus_stb | input | 1 | Apply `clr_bus` |
| clr_bus | input | 8 | Set of lines to clear, one bit per line |
| cond_n | output | 1 | Active-low condition: an admitted request is pending |
| vec_valid | output | 1 | `vec_idx` holds an admitted index |
| vec_idx | output | 3 | Admitted vector index, zero when not valid |

## Verification
Two functions can land in the same cycle: a clear and a fresh rising edge on the same line, and a fence load together with a fence increment. The bench provokes the first by raising a line in the very cycle that the clear bus names it. It provokes a related case by clearing the stored line through the decoder while a different line rises. The outcome is judged from the encoded index on the next cycle. For the fence, both strobes are asserted together and the value read back is compared with the written value. All 256 request patterns are swept against every fence value and several masks, and the expected outputs are computed arithmetically from the highest set bit.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  localparam int unsigned LINES_DEF = 8;

  typedef enum logic [1:0] {
    FOP_HOLD = 2'd0,
    FOP_BUMP = 2'd1,
    FOP_LOAD = 2'd2
  } fence_op_e;
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q;
  logic [N-1:0] rise;

  for (genvar g = 0; g < N; g++) begin : g_line
    assign rise[g] = req_i[g] & ~req_q[g];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        req_q[g]  <= 1'b0;
        pend_o[g] <= 1'b0;
      end else begin
        req_q[g]  <= req_i[g];
        pend_o[g] <= (pend_o[g] & ~clr_i[g]) | rise[g];
      end
    end
  end

  // R2
  edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_o & $past(rise)) == $past(rise)));

  // R8
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_o & $past(clr_i & ~rise)) == '0));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 3
) (
  input  logic [N-1:0] act_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (act_i[i]) begin
        any_o = 1'b1;
        idx_o = W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_fence_unit.sv
module irq_fence_unit
  import nirq_pkg::*;
#(
  parameter int unsigned W  = 3,
  parameter int unsigned FW = W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fence_op_e     op_i,
  input  logic [FW-1:0] wdata_i,
  input  logic [W-1:0]  idx_i,
  input  logic          any_i,
  output logic [FW-1:0] fence_o,
  output logic          pass_o
);
  logic [FW-1:0] idx_ext;
  logic [FW-1:0] idx_next;

  assign idx_ext  = {1'b0, idx_i};
  assign idx_next = idx_ext + FW'(1);
  assign pass_o   = any_i && (idx_ext >= fence_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fence_o <= '0;
    end else begin
      unique case (op_i)
        FOP_LOAD: fence_o <= wdata_i;
        FOP_BUMP: fence_o <= idx_next;
        default:  fence_o <= fence_o;
      endcase
    end
  end

  // R6
  fence_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == FOP_BUMP) |=> (fence_o == $past(idx_ext) + FW'(1)));

  // R6
  fence_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == FOP_LOAD) |=> (fence_o == $past(wdata_i)));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nirq_pkg::*;
#(
  parameter int unsigned NUM_LINES = LINES_DEF,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES),
  localparam int unsigned FENCE_W  = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 mask_wr,
  input  logic [NUM_LINES-1:0] mask_wdata,
  output logic [NUM_LINES-1:0] mask_rd,
  input  logic                 fence_wr,
  input  logic                 fence_inc,
  input  logic [FENCE_W-1:0]   fence_wdata,
  output logic [FENCE_W-1:0]   fence_rd,
  input  logic                 cap_stb,
  input  logic                 clr_stb,
  input  logic                 clr_bus_stb,
  input  logic [NUM_LINES-1:0] clr_bus,
  output logic                 cond_n,
  output logic                 vec_valid,
  output logic [IDX_W-1:0]     vec_idx
);
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] act;
  logic [NUM_LINES-1:0] clr_dec;
  logic [NUM_LINES-1:0] clr_all;
  logic [IDX_W-1:0]     svc_q;
  logic [IDX_W-1:0]     enc_idx;
  logic                 enc_any;
  logic                 pass;
  fence_op_e            fop;

  // mask register
  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_wr) mask_q <= mask_wdata;
  end
  assign mask_rd = mask_q;

  // serviced-index store
  always_ff @(posedge clk) begin
    if (!rst_n)       svc_q <= '0;
    else if (cap_stb) svc_q <= enc_idx;
  end

  // enabled clear decoder
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_dec
    assign clr_dec[g] = clr_stb && (svc_q == IDX_W'(g));
  end
  assign clr_all = clr_dec | (clr_bus_stb ? clr_bus : '0);

  irq_latch_bank #(.N(NUM_LINES)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (irq_in),
    .clr_i  (clr_all),
    .pend_o (pend)
  );

  assign act = pend & mask_q;

  irq_prio_enc #(.N(NUM_LINES), .W(IDX_W)) u_enc (
    .act_i (act),
    .any_o (enc_any),
    .idx_o (enc_idx)
  );

  always_comb begin
    if (fence_wr)       fop = FOP_LOAD;
    else if (fence_inc) fop = FOP_BUMP;
    else                fop = FOP_HOLD;
  end

  irq_fence_unit #(.W(IDX_W), .FW(FENCE_W)) u_fence (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (fop),
    .wdata_i (fence_wdata),
    .idx_i   (enc_idx),
    .any_i   (enc_any),
    .fence_o (fence_rd),
    .pass_o  (pass)
  );

  assign cond_n    = ~pass;
  assign vec_valid = pass;
  assign vec_idx   = pass ? enc_idx : '0;

  // R4
  enc_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_any |-> ((act >> enc_idx) == NUM_LINES'(1)));

  // R5
  fence_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_n |-> (fence_rd <= {1'b0, vec_idx}));

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> (vec_idx == '0));

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0) |-> cond_n);

  // R7
  dec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !(irq_in[svc_q] && !$past(irq_in[svc_q]))) |=> !pend[$past(svc_q)]);
endmodule

// File: tb/nest_irq_ctrl_bench.sv
module nest_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       mask_wr = 1'b0;
  logic [7:0] mask_wdata = '0;
  logic [7:0] mask_rd;
  logic       fence_wr = 1'b0;
  logic       fence_inc = 1'b0;
  logic [3:0] fence_wdata = '0;
  logic [3:0] fence_rd;
  logic       cap_stb = 1'b0;
  logic       clr_stb = 1'b0;
  logic       clr_bus_stb = 1'b0;
  logic [7:0] clr_bus = '0;
  logic       cond_n;
  logic       vec_valid;
  logic [2:0] vec_idx;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nest_irq_ctrl u_nest_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .mask_rd(mask_rd),
    .fence_wr(fence_wr), .fence_inc(fence_inc), .fence_wdata(fence_wdata),
    .fence_rd(fence_rd), .cap_stb(cap_stb), .clr_stb(clr_stb),
    .clr_bus_stb(clr_bus_stb), .clr_bus(clr_bus),
    .cond_n(cond_n), .vec_valid(vec_valid), .vec_idx(vec_idx)
  );

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // packs {cond_n, vec_valid, vec_idx}
  function automatic int outs();
    return {cond_n, vec_valid, vec_idx};
  endfunction

  function automatic int model(input logic [7:0] act, input int f);
    int hi = 0;
    bit any = 1'b0;
    bit v;
    for (int i = 0; i < 8; i++) if (act[i]) begin hi = i; any = 1'b1; end
    v = any && (hi >= f);
    return {!v, v, v ? 3'(hi) : 3'd0};
  endfunction

  task automatic expect_out(input string req, input int exp);
    chk(outs() == exp, req, outs(), exp);
  endtask

  // clear everything, load mask and fence, then raise pattern p
  task automatic run_case(input logic [7:0] p, input logic [7:0] m, input logic [3:0] f);
    irq_in = '0; clr_bus = 8'hFF; clr_bus_stb = 1'b1;
    mask_wr = 1'b1; mask_wdata = m; fence_wr = 1'b1; fence_wdata = f;
    step;
    clr_bus_stb = 1'b0; mask_wr = 1'b0; fence_wr = 1'b0; irq_in = p;
    step;
    irq_in = '0;
  endtask

  initial begin
    repeat (3) step;
    rst_n = 1'b1;
    step;
    // R1 reset state
    expect_out("R1", {1'b1, 1'b0, 3'd0});
    chk(mask_rd == 8'hFF, "R1 mask", mask_rd, 8'hFF);
    chk(fence_rd == 4'd0, "R1 fence", fence_rd, 0);

    // R4 / R5 / R8: every pattern against every fence, full mask
    for (int p = 0; p < 256; p++) begin
      for (int f = 0; f <= 8; f++) begin
        run_case(8'(p), 8'hFF, 4'(f));
        expect_out("R4/R5", model(8'(p), f));
      end
    end
    // R10 readback
    run_case(8'h00, 8'h3C, 4'd7);
    chk(mask_rd == 8'h3C, "R10 mask", mask_rd, 8'h3C);
    chk(fence_rd == 4'd7, "R10 fence", fence_rd, 7);

    // R3: masks over every pattern
    for (int p = 0; p < 256; p++) begin
      run_case(8'(p), 8'h00, 4'd0);
      expect_out("R3 m00", model(8'h00, 0));
      run_case(8'(p), 8'h0F, 4'd2);
      expect_out("R3 m0F", model(8'(p) & 8'h0F, 2));
      run_case(8'(p), 8'hA5, 4'd0);
      expect_out("R3 mA5", model(8'(p) & 8'hA5, 0));
    end
    // R3 unmask reveals hidden line
    run_case(8'h81, 8'h01, 4'd0);
    expect_out("R3 hidden", {1'b0, 1'b1, 3'd0});
    mask_wr = 1'b1; mask_wdata = 8'hFF; step; mask_wr = 1'b0;
    expect_out("R3 reveal", {1'b0, 1'b1, 3'd7});

    // R2 level held after clear does not re-set
    run_case(8'h00, 8'hFF, 4'd0);
    irq_in = 8'h08; step;
    expect_out("R2 set", {1'b0, 1'b1, 3'd3});
    clr_bus = 8'h08; clr_bus_stb = 1'b1; step; clr_bus_stb = 1'b0;
    step;
    expect_out("R2 held", {1'b1, 1'b0, 3'd0});
    irq_in = 8'h00; step; irq_in = 8'h08; step;
    expect_out("R2 rearm", {1'b0, 1'b1, 3'd3});
    irq_in = 8'h00;

    // R8 subset clear
    run_case(8'hFF, 8'hFF, 4'd0);
    clr_bus = 8'hF0; clr_bus_stb = 1'b1; step; clr_bus_stb = 1'b0;
    expect_out("R8 subset", {1'b0, 1'b1, 3'd3});

    // R9 clear and new edge on the same line
    run_case(8'h10, 8'hFF, 4'd0);
    step;
    irq_in = 8'h10; clr_bus = 8'h10; clr_bus_stb = 1'b1; step;
    clr_bus_stb = 1'b0; irq_in = 8'h00;
    expect_out("R9", {1'b0, 1'b1, 3'd4});

    // R7 capture and decoder clear
    run_case(8'hA0, 8'hFF, 4'd0);
    cap_stb = 1'b1; step; cap_stb = 1'b0;
    clr_stb = 1'b1; step; clr_stb = 1'b0;
    expect_out("R7 one", {1'b0, 1'b1, 3'd5});
    cap_stb = 1'b1; step; cap_stb = 1'b0;
    irq_in = 8'h40; clr_stb = 1'b1; step; clr_stb = 1'b0; irq_in = 8'h00;
    expect_out("R7 other", {1'b0, 1'b1, 3'd6});
    clr_bus = 8'h40; clr_bus_stb = 1'b1; step; clr_bus_stb = 1'b0;
    expect_out("R7 empty", {1'b1, 1'b0, 3'd0});

    // R6 fence bump, nesting, and load priority
    run_case(8'h24, 8'hFF, 4'd0);
    fence_inc = 1'b1; step; fence_inc = 1'b0;
    chk(fence_rd == 4'd6, "R6 bump", fence_rd, 6);
    expect_out("R6 blocked", {1'b1, 1'b0, 3'd0});
    irq_in = 8'h80; step; irq_in = 8'h00;
    expect_out("R6 nest", {1'b0, 1'b1, 3'd7});
    fence_inc = 1'b1; step; fence_inc = 1'b0;
    chk(fence_rd == 4'd8, "R6 top", fence_rd, 8);
    expect_out("R6 shut", {1'b1, 1'b0, 3'd0});
    fence_inc = 1'b1; fence_wr = 1'b1; fence_wdata = 4'd3; step;
    fence_inc = 1'b0; fence_wr = 1'b0;
    chk(fence_rd == 4'd3, "R6 wr wins", fence_rd, 3);
    expect_out("R6 reopen", {1'b0, 1'b1, 3'd7});

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule